// File: doc/BRIEF.md
# I/O Clock Rate Generator with Control Register

This block produces a slower I/O clock from the bus clock. A 3-bit rate field in an 8-bit control register sets how far the clock is divided. The even rate codes give divide-by-2, 4, 6 or 8, each with a 50% duty cycle. Every odd code selects divide-by-1. In that mode the I/O clock output does not follow the bus clock. It is held at a constant high level, and devices that need a full-speed clock take the bus clock directly.

The control register can only be reached through a dedicated register access port. Ordinary external I/O cycles cannot reach it. Each access, read or write, is also shown on the external address bus as a pseudo transaction that lasts exactly two bus clock cycles. During it the register address sits in the low address byte and all upper address bits are zero. The bus control strobes stay inactive the whole time. A busy flag covers the pseudo transaction, and any request made while busy is dropped.

A rate change is applied only at a rising edge of the I/O clock. The phase that is already running therefore always finishes at its old length, and no runt pulse reaches the output.

Top module: `io_rate_ctrl`

## Requirements
- R1: After reset the rate field is 000. The I/O clock runs at divide-by-2, the bus is idle (`bus_addr_valid` low, `acc_busy` low) and a read of the control register returns 0x00.
- R2: Rate code 000 gives divide-by-2, 010 gives divide-by-4, 100 gives divide-by-6 and 110 gives divide-by-8. For code c the output is high for c/2+1 bus clocks and then low for c/2+1 bus clocks.
- R3: Rate codes 001, 011, 101 and 111 select divide-by-1. While one of them is in effect, `io_clk` stays at constant 1.
- R4: Bits 7:3 of the control register always read as 0, and writing to them changes nothing. The rate field is bits 2:0.
- R5: An accepted request puts `bus_addr_valid` high for exactly two bus clock cycles. It starts in the cycle after the request is sampled. In both cycles `bus_addr` holds the request address in bits 7:0 and zeros in bits 31:8.
- R6: Every bit of `bus_strobe_n` (active low) is 1 at all times, including during the pseudo transaction.
- R7: A read gives `rd_valid` = 1 and the register value on `rd_data` in the second pseudo-transaction cycle only. At all other times `rd_data` is 0 and `rd_valid` is 0.
- R8: `acc_busy` is high during both pseudo-transaction cycles. A request sampled while busy is dropped: it starts no pseudo transaction and writes nothing. The busy flag falls in the cycle after the second pseudo-transaction cycle.
- R9: A written rate is applied at the next rising edge of `io_clk`. Coming out of divide-by-1, it is applied at the next bus clock edge and starts with a high phase. The phase running when the write lands completes at the old length.
- R10: The control register lives at address 0x11. An access to any other address still produces the pseudo transaction, but a read returns 0 and a write changes nothing.
- R11: A write takes effect at the end of its pseudo transaction, so a read that follows sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Register access request, sampled when not busy |
| acc_addr | input | 8 | Register address of the request |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 8 | Write data |
| acc_busy | output | 1 | Pseudo transaction in progress |
| rd_data | output | 8 | Read data, non-zero only in the read cycle |
| rd_valid | output | 1 | Read data valid |
| io_clk | output | 1 | Divided I/O clock |
| bus_addr | output | 32 | Pseudo-transaction address |
| bus_addr_valid | output | 1 | Pseudo-transaction address phase |
| bus_strobe_n | output | 5 | External bus control strobes, active low |

## Verification
The hardest case to reach is a rate write that commits partway through an I/O clock phase. To create it, the bench waits for a rising edge at divide-by-8 and issues a divide-by-2 write in the very next cycle. The write then commits inside the running high phase. The bench records `io_clk` cycle by cycle and checks that one full 4-cycle high phase and one full 4-cycle low phase come out before the 1-cycle phases begin. The dropped-while-busy case is reached by raising a second, conflicting write in the first pseudo-transaction cycle.

// File: rtl/iorate_pkg.sv
package iorate_pkg;

   localparam int CTRL_W = 8;
   localparam int RATE_W = 3;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ONE  = 2'd1,
      PH_TWO  = 2'd2
   } pseudo_phase_t;

   // Half-period minus one, in bus clocks, for an even rate code.
   function automatic logic [RATE_W-2:0] half_minus_one(input logic [RATE_W-1:0] code);
      return code[RATE_W-1:1];
   endfunction

   function automatic logic is_div1(input logic [RATE_W-1:0] code);
      return code[0];
   endfunction

endpackage

// File: rtl/iorate_seq.sv
module iorate_seq
   import iorate_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int REG_AW = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_req,
   input  logic [REG_AW-1:0] acc_addr,
   input  logic              acc_we,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic              busy,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_addr_valid,
   output logic [REG_AW-1:0] cur_addr,
   output logic [DATA_W-1:0] cur_wdata,
   output logic              commit_wr,
   output logic              read_slot
);

   localparam int PAD_W = ADDR_W - REG_AW;

   generate
      if (PAD_W < 1) begin : g_bad_addr
         $error("ADDR_W must exceed REG_AW");
      end
      if (REG_AW < 1 || DATA_W < 1) begin : g_bad_width
         $error("REG_AW and DATA_W must be positive");
      end
   endgenerate

   pseudo_phase_t phase_q, phase_d;
   logic              we_q;
   logic [REG_AW-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              accept;

   assign accept = acc_req && (phase_q == PH_IDLE);

   always_comb begin
      phase_d = phase_q;
      case (phase_q)
         PH_IDLE: if (accept) phase_d = PH_ONE;
         PH_ONE:  phase_d = PH_TWO;
         PH_TWO:  phase_d = PH_IDLE;
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else begin
         phase_q <= phase_d;
         if (accept) begin
            we_q    <= acc_we;
            addr_q  <= acc_addr;
            wdata_q <= acc_wdata;
         end
      end
   end

   assign busy           = (phase_q != PH_IDLE);
   assign bus_addr_valid = busy;
   assign bus_addr       = busy ? {{PAD_W{1'b0}}, addr_q} : '0;
   assign cur_addr       = addr_q;
   assign cur_wdata      = wdata_q;
   assign commit_wr      = (phase_q == PH_TWO) && we_q;
   assign read_slot      = (phase_q == PH_TWO) && !we_q;

endmodule

// File: rtl/iorate_regs.sv
module iorate_regs
   import iorate_pkg::*;
#(
   parameter int              REG_AW    = 8,
   parameter int              DATA_W    = 8,
   parameter int              FIELD_W   = 3,
   parameter logic [REG_AW-1:0] CTRL_ADDR = 8'h11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_AW-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [FIELD_W-1:0] rate_field,
   output logic [DATA_W-1:0]  rd_word
);

   localparam int RSVD_W = DATA_W - FIELD_W;

   logic [FIELD_W-1:0] field_q;
   logic               hit;

   assign hit = (addr == CTRL_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q <= '0;
      end else if (wr_en && hit) begin
         field_q <= wdata[FIELD_W-1:0];
      end
   end

   assign rate_field = field_q;

   generate
      if (RSVD_W > 0) begin : g_pad
         assign rd_word = hit ? {{RSVD_W{1'b0}}, field_q} : '0;
      end else if (RSVD_W == 0) begin : g_full
         assign rd_word = hit ? field_q : '0;
      end else begin : g_bad
         $error("FIELD_W must not exceed DATA_W");
      end
   endgenerate

endmodule

// File: rtl/iorate_clkgen.sv
module iorate_clkgen
   import iorate_pkg::*;
#(
   parameter int FIELD_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [FIELD_W-1:0] pend_code,
   output logic               io_clk,
   output logic [FIELD_W-1:0] act_code
);

   localparam int CNT_W = FIELD_W - 1;

   generate
      if (FIELD_W < 2) begin : g_bad_field
         $error("FIELD_W must be at least 2");
      end
   endgenerate

   logic [FIELD_W-1:0] cur_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               out_q;
   logic               phase_end;

   assign phase_end = (cnt_q == cur_q[FIELD_W-1:1]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
         cnt_q <= '0;
         out_q <= 1'b1;
      end else if (cur_q[0]) begin
         // divide-by-1: hold high, pick up a new code at once
         out_q <= 1'b1;
         cnt_q <= '0;
         cur_q <= pend_code;
      end else if (phase_end) begin
         cnt_q <= '0;
         if (!out_q) begin
            // rising edge: the only point a new code is adopted
            cur_q <= pend_code;
            out_q <= 1'b1;
         end else begin
            out_q <= 1'b0;
         end
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign io_clk   = out_q;
   assign act_code = cur_q;

endmodule

// File: rtl/io_rate_ctrl.sv
module io_rate_ctrl
   import iorate_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter int              REG_AW    = 8,
   parameter int              DATA_W    = CTRL_W,
   parameter int              FIELD_W   = RATE_W,
   parameter int              STROBE_N  = 5,
   parameter logic [REG_AW-1:0] CTRL_ADDR = 8'h11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_req,
   input  logic [REG_AW-1:0]   acc_addr,
   input  logic                acc_we,
   input  logic [DATA_W-1:0]   acc_wdata,
   output logic                acc_busy,
   output logic [DATA_W-1:0]   rd_data,
   output logic                rd_valid,
   output logic                io_clk,
   output logic [ADDR_W-1:0]   bus_addr,
   output logic                bus_addr_valid,
   output logic [STROBE_N-1:0] bus_strobe_n
);

   generate
      if (STROBE_N < 1) begin : g_bad_strobe
         $error("STROBE_N must be positive");
      end
   endgenerate

   logic [REG_AW-1:0]  cur_addr;
   logic [DATA_W-1:0]  cur_wdata;
   logic               commit_wr;
   logic               read_slot;
   logic [FIELD_W-1:0] rate_field;
   logic [FIELD_W-1:0] act_code;
   logic [DATA_W-1:0]  rd_word;

   iorate_seq #(
      .ADDR_W (ADDR_W),
      .REG_AW (REG_AW),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_req        (acc_req),
      .acc_addr       (acc_addr),
      .acc_we         (acc_we),
      .acc_wdata      (acc_wdata),
      .busy           (acc_busy),
      .bus_addr       (bus_addr),
      .bus_addr_valid (bus_addr_valid),
      .cur_addr       (cur_addr),
      .cur_wdata      (cur_wdata),
      .commit_wr      (commit_wr),
      .read_slot      (read_slot)
   );

   iorate_regs #(
      .REG_AW    (REG_AW),
      .DATA_W    (DATA_W),
      .FIELD_W   (FIELD_W),
      .CTRL_ADDR (CTRL_ADDR)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (commit_wr),
      .addr       (cur_addr),
      .wdata      (cur_wdata),
      .rate_field (rate_field),
      .rd_word    (rd_word)
   );

   iorate_clkgen #(
      .FIELD_W (FIELD_W)
   ) u_clkgen (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_code (rate_field),
      .io_clk    (io_clk),
      .act_code  (act_code)
   );

   assign rd_valid     = read_slot;
   assign rd_data      = read_slot ? rd_word : '0;
   assign bus_strobe_n = {STROBE_N{1'b1}};

endmodule

// File: rtl/io_rate_ctrl_chk.sv
module io_rate_ctrl_chk #(
   parameter int ADDR_W  = 32,
   parameter int REG_AW  = 8,
   parameter int DATA_W  = 8,
   parameter int FIELD_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_req,
   input logic               acc_busy,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_addr_valid,
   input logic               rd_valid,
   input logic [DATA_W-1:0]  rd_data,
   input logic               io_clk,
   input logic [FIELD_W-1:0] act_code
);

   AST_ADDR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr_valid |-> (bus_addr[ADDR_W-1:REG_AW] == '0)); // R5

   AST_PSEUDO_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_addr_valid) |=> bus_addr_valid); // R5

   AST_PSEUDO_END: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_valid && $past(bus_addr_valid)) |=> !bus_addr_valid); // R5

   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_valid && $past(bus_addr_valid)) |-> $stable(bus_addr)); // R5

   AST_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (bus_addr_valid && $past(bus_addr_valid))); // R7

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_data[DATA_W-1:FIELD_W] == '0)); // R4

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !acc_busy) |=> (bus_addr_valid && acc_busy)); // R8

   AST_DIV1_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      act_code[0] |-> io_clk); // R3

endmodule

bind io_rate_ctrl io_rate_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .REG_AW  (REG_AW),
   .DATA_W  (DATA_W),
   .FIELD_W (FIELD_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .acc_req        (acc_req),
   .acc_busy       (acc_busy),
   .bus_addr       (bus_addr),
   .bus_addr_valid (bus_addr_valid),
   .rd_valid       (rd_valid),
   .rd_data        (rd_data),
   .io_clk         (io_clk),
   .act_code       (act_code)
);

// File: tb/tb_io_rate_ctrl.sv
`timescale 1ns/1ps
module tb_io_rate_ctrl;

   localparam logic [7:0] CTRL = 8'h11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_req = 1'b0;
   logic [7:0]  acc_addr = '0;
   logic        acc_we = 1'b0;
   logic [7:0]  acc_wdata = '0;
   logic        acc_busy;
   logic [7:0]  rd_data;
   logic        rd_valid;
   logic        io_clk;
   logic [31:0] bus_addr;
   logic        bus_addr_valid;
   logic [4:0]  bus_strobe_n;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   io_rate_ctrl dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .acc_req        (acc_req),
      .acc_addr       (acc_addr),
      .acc_we         (acc_we),
      .acc_wdata      (acc_wdata),
      .acc_busy       (acc_busy),
      .rd_data        (rd_data),
      .rd_valid       (rd_valid),
      .io_clk         (io_clk),
      .bus_addr       (bus_addr),
      .bus_addr_valid (bus_addr_valid),
      .bus_strobe_n   (bus_strobe_n)
   );

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
      end
   endtask

   // One access through the register port, checking the pseudo transaction.
   task automatic access(input logic [7:0] a, input bit we, input logic [7:0] wd,
                         input bit inject, output logic [7:0] rd);
      rd = '0;
      @(negedge clk);
      acc_req = 1'b1; acc_addr = a; acc_we = we; acc_wdata = wd;
      @(negedge clk);
      acc_req = 1'b0;
      if (inject) begin
         acc_req = 1'b1; acc_addr = CTRL; acc_we = 1'b1; acc_wdata = 8'h06;
      end
      chk(bus_addr_valid == 1'b1, "R5 cycle1 valid", bus_addr_valid, 1);
      chk(bus_addr == {24'h0, a}, "R5 cycle1 addr", bus_addr, {24'h0, a});
      chk(acc_busy == 1'b1, "R8 busy cycle1", acc_busy, 1);
      chk(bus_strobe_n == 5'h1f, "R6 strobes cycle1", bus_strobe_n, 5'h1f);
      chk(rd_valid == 1'b0 && rd_data == 8'h0, "R7 no data cycle1", rd_data, 0);
      @(negedge clk);
      acc_req = 1'b0;
      chk(bus_addr_valid == 1'b1, "R5 cycle2 valid", bus_addr_valid, 1);
      chk(bus_addr == {24'h0, a}, "R5 cycle2 addr", bus_addr, {24'h0, a});
      chk(acc_busy == 1'b1, "R8 busy cycle2", acc_busy, 1);
      chk(bus_strobe_n == 5'h1f, "R6 strobes cycle2", bus_strobe_n, 5'h1f);
      chk(rd_valid == !we, "R7 rd_valid cycle2", rd_valid, !we);
      rd = rd_data;
      @(negedge clk);
      chk(bus_addr_valid == 1'b0, "R5 end after two", bus_addr_valid, 0);
      chk(acc_busy == 1'b0, "R8 busy falls", acc_busy, 0);
      chk(rd_valid == 1'b0 && rd_data == 8'h0, "R7 data cleared", rd_data, 0);
   endtask

   // Measure one full period beginning at a rising edge of io_clk.
   task automatic measure(output int hi, output int lo);
      logic prev;
      hi = 0; lo = 0;
      prev = io_clk;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!prev && io_clk) break;
         prev = io_clk;
      end
      hi = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!io_clk) break;
         hi++;
      end
      lo = 1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (io_clk) break;
         lo++;
      end
   endtask

   task automatic t_reset();
      logic [7:0] r;
      int hi, lo;
      chk(bus_addr_valid == 1'b0 && acc_busy == 1'b0, "R1 idle bus", bus_addr_valid, 0);
      chk(rd_data == 8'h0 && rd_valid == 1'b0, "R1 R7 idle data", rd_data, 0);
      chk(bus_strobe_n == 5'h1f, "R6 strobes idle", bus_strobe_n, 5'h1f);
      access(CTRL, 1'b0, 8'h0, 1'b0, r);
      chk(r == 8'h00, "R1 reset value", r, 0);
      measure(hi, lo);
      chk(hi == 1 && lo == 1, "R1 divide-by-2 at reset", {hi[15:0], lo[15:0]}, 32'h0001_0001);
   endtask

   task automatic t_even_rates();
      logic [7:0] r;
      int hi, lo;
      for (int c = 0; c < 8; c += 2) begin
         access(CTRL, 1'b1, 8'(c), 1'b0, r);
         access(CTRL, 1'b0, 8'h0, 1'b0, r);
         chk(r == 8'(c), "R11 read after write", r, c);
         measure(hi, lo);
         measure(hi, lo);
         chk(hi == c / 2 + 1 && lo == c / 2 + 1, "R2 even ratio duty",
             {hi[15:0], lo[15:0]}, {16'(c / 2 + 1), 16'(c / 2 + 1)});
      end
   endtask

   task automatic t_odd_rates();
      logic [7:0] r;
      int lows;
      for (int c = 1; c < 8; c += 2) begin
         access(CTRL, 1'b1, 8'(c), 1'b0, r);
         repeat (20) @(negedge clk);
         lows = 0;
         for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (!io_clk) lows++;
         end
         chk(lows == 0, "R3 odd code holds high", lows, 0);
      end
      // leaving divide-by-1 for divide-by-4
      access(CTRL, 1'b1, 8'h02, 1'b0, r);
      begin
         int hi, lo;
         measure(hi, lo);
         chk(hi == 2 && lo == 2, "R9 exit divide-by-1", {hi[15:0], lo[15:0]}, 32'h0002_0002);
      end
   endtask

   task automatic t_reserved();
      logic [7:0] r;
      access(CTRL, 1'b1, 8'hFD, 1'b0, r);
      access(CTRL, 1'b0, 8'h0, 1'b0, r);
      chk(r == 8'h05, "R4 reserved bits read zero", r, 8'h05);
      access(CTRL, 1'b1, 8'hF8, 1'b0, r);
      access(CTRL, 1'b0, 8'h0, 1'b0, r);
      chk(r == 8'h00, "R4 reserved write ignored", r, 8'h00);
   endtask

   task automatic t_other_addr();
      logic [7:0] r;
      access(CTRL, 1'b1, 8'h04, 1'b0, r);
      access(8'h12, 1'b1, 8'h06, 1'b0, r);
      access(8'h12, 1'b0, 8'h0, 1'b0, r);
      chk(r == 8'h00, "R10 other address reads zero", r, 0);
      access(8'h10, 1'b0, 8'h0, 1'b0, r);
      chk(r == 8'h00, "R10 neighbour address reads zero", r, 0);
      access(CTRL, 1'b0, 8'h0, 1'b0, r);
      chk(r == 8'h04, "R10 write elsewhere no effect", r, 8'h04);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] r;
      access(CTRL, 1'b1, 8'h02, 1'b0, r);
      access(CTRL, 1'b0, 8'h0, 1'b1, r);   // conflicting write raised in cycle 1
      acc_req = 1'b0;
      @(negedge clk);
      chk(bus_addr_valid == 1'b0, "R8 no extra pseudo transaction", bus_addr_valid, 0);
      access(CTRL, 1'b0, 8'h0, 1'b0, r);
      chk(r == 8'h02, "R8 write while busy dropped", r, 8'h02);
   endtask

   task automatic t_change_timing();
      logic [7:0] r;
      logic prev;
      logic [23:0] s;
      logic [23:0] exp;
      access(CTRL, 1'b1, 8'h06, 1'b0, r);
      repeat (20) @(negedge clk);
      prev = io_clk;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (!prev && io_clk) break;
         prev = io_clk;
      end
      s = '0;
      fork
         begin
            s[0] = io_clk;
            for (int k = 1; k < 24; k++) begin
               @(negedge clk);
               s[k] = io_clk;
            end
         end
         begin
            access(CTRL, 1'b1, 8'h00, 1'b0, r);
         end
      join
      // bit k = io_clk k cycles after the rise: 4 high, 4 low, then 1/1
      exp = 24'h55_550F;
      chk(s == exp, "R9 change waits for rising edge", s, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_even_rates();
      t_odd_rates();
      t_reserved();
      t_other_addr();
      t_busy_ignore();
      t_change_timing();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule